// File: doc/BRIEF.md
# Program Counter and Instruction Fetch Unit

This block holds the byte address of the instruction being executed and presents the 16-bit instruction word found there. The instruction memory is a small internal byte array. Each word takes two consecutive bytes, and the byte at the lower address carries the upper half of the word, which holds the opcode. A byte-wide load port writes this array, and a testbench normally uses it to place a program before reset is released.

On every clock edge the unit chooses the next PC:

- It steps to the following word by default.
- It takes a forward or backward relative branch by the 8-bit immediate when the comparison flag is set.
- It freezes when a halt opcode is decoded.

A halt is sticky. Once it is taken, the PC and the halted indication hold until reset, whatever the flag, the instruction or the load port do. All PC arithmetic wraps modulo the size of the memory.

Top module: `pc_fetch_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the PC to 0 and clears the halted output; while rst is high, both hold at those values.
- R2: The instruction output is {mem[pc], mem[(pc+1) mod 256]}, so the byte at the lower address forms bits 15:8. It is combinational from the PC and from the memory contents.
- R3: When not halted and the opcode (bits 15:12) is none of 1001, 1010 or 1011, the next PC is the current PC + 2, whatever the flag.
- R4: Opcode 1011 with the flag at 1 loads the PC with the current PC minus the immediate (bits 7:0); for example, 38 with immediate 12 gives 26.
- R5: Opcode 1010 with the flag at 1 loads the PC with the current PC plus the immediate (bits 7:0).
- R6: Opcode 1010 or 1011 with the flag at 0 advances the PC by 2.
- R7: Opcode 1001 sets halted at the next edge and leaves the PC unchanged. After that, the PC and halted stay frozen until reset, regardless of the flag, the instruction or memory writes.
- R8: Every PC result wraps modulo 256.
- R9: A load write (load_en high at an edge) stores load_data at load_addr, and the new byte appears in the instruction output from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flag_i | input | 1 | Comparison flag qualifying branches |
| load_en_i | input | 1 | Byte write enable for the instruction memory |
| load_addr_i | input | 8 | Byte address for a memory write |
| load_data_i | input | 8 | Byte written to the memory |
| pc_o | output | 8 | Current instruction byte address |
| instr_o | output | 16 | Instruction word fetched at pc_o |
| halted_o | output | 1 | Sticky halt indication |

## Verification
Every cycle, the assertions check the PC transition chosen from the observed opcode, flag and immediate:

- the step of two,
- the forward and backward taken branches,
- the untaken branch,
- entry into halt,
- the frozen PC and halted state while halted,
- the reset values.

Only the bench scenarios can show the following:

- that the byte ordering of the fetched word matches what was loaded across the whole array;
- that the PC returns to 0 after a full pass of the memory;
- that rewriting memory under a halted unit has no effect on the PC.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
    localparam int BYTE_W  = 8;
    localparam int INSTR_W = 16;
    localparam int OP_W    = 4;
    localparam int IMM_W   = 8;

    localparam logic [OP_W-1:0] OP_HALT = 4'b1001;
    localparam logic [OP_W-1:0] OP_BFWD = 4'b1010;
    localparam logic [OP_W-1:0] OP_BBWD = 4'b1011;

    typedef enum logic [1:0] {
        MV_STEP,
        MV_FWD,
        MV_BWD,
        MV_HOLD
    } move_e;
endpackage

// File: rtl/pcf_imem.sv
module pcf_imem #(
    parameter int ADDR_W  = 8,
    parameter int BYTE_W  = 8,
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [INSTR_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = INSTR_W / BYTE_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // lane 0 is the lowest address and lands in the top byte of the word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        assign lane_addr = rd_addr + ADDR_W'(l);
        assign rd_word[INSTR_W-1-l*BYTE_W -: BYTE_W] = mem_q[lane_addr];
    end
endmodule

// File: rtl/pcf_next_pc.sv
module pcf_next_pc
    import pcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STEP   = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OP_W-1:0]   opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic              flag,
    input  logic              halted,
    output logic [ADDR_W-1:0] pc_next,
    output logic              halt_next
);
    move_e             move;
    logic [ADDR_W-1:0] offset;

    assign offset = ADDR_W'(imm);

    always_comb begin
        move = MV_STEP;
        if (halted || opcode == OP_HALT) begin
            move = MV_HOLD;
        end else if (flag && opcode == OP_BFWD) begin
            move = MV_FWD;
        end else if (flag && opcode == OP_BBWD) begin
            move = MV_BWD;
        end
    end

    always_comb begin
        unique case (move)
            MV_FWD:  pc_next = pc + offset;
            MV_BWD:  pc_next = pc - offset;
            MV_HOLD: pc_next = pc;
            default: pc_next = pc + ADDR_W'(STEP);
        endcase
        halt_next = (move == MV_HOLD);
    end
endmodule

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit
    import pcf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flag_i,
    input  logic               load_en_i,
    input  logic [ADDR_W-1:0]  load_addr_i,
    input  logic [BYTE_W-1:0]  load_data_i,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [INSTR_W-1:0] instr_o,
    output logic               halted_o
);
    localparam int STEP = INSTR_W / BYTE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              halted;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0]  pc_calc;
    logic               halt_calc;
    logic [INSTR_W-1:0] word;

    pcf_imem #(
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W),
        .INSTR_W (INSTR_W)
    ) u_imem (
        .clk     (clk),
        .wr_en   (load_en_i),
        .wr_addr (load_addr_i),
        .wr_data (load_data_i),
        .rd_addr (st_q.pc),
        .rd_word (word)
    );

    pcf_next_pc #(
        .ADDR_W (ADDR_W),
        .STEP   (STEP)
    ) u_next (
        .pc        (st_q.pc),
        .opcode    (word[INSTR_W-1 -: OP_W]),
        .imm       (word[IMM_W-1:0]),
        .flag      (flag_i),
        .halted    (st_q.halted),
        .pc_next   (pc_calc),
        .halt_next (halt_calc)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.pc     = pc_calc;
            st_d.halted = halt_calc;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o     = st_q.pc;
    assign halted_o = st_q.halted;
    assign instr_o  = word;
endmodule

// File: rtl/pcf_checker.sv
module pcf_checker (
    input logic        clk,
    input logic        rst,
    input logic        flag_i,
    input logic [7:0]  pc_o,
    input logic [15:0] instr_o,
    input logic        halted_o
);
    logic [3:0] op;
    logic [7:0] imm;
    logic       rst_q;

    assign op  = instr_o[15:12];
    assign imm = instr_o[7:0];

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1
    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            reset_state_chk: assert (pc_o == 8'd0 && !halted_o);
        end
    end

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted_o && op != 4'b1001 && op != 4'b1010 && op != 4'b1011)
        |=> pc_o == 8'($past(pc_o) + 8'd2));

    // R4
    bwd_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted_o && op == 4'b1011 && flag_i)
        |=> pc_o == 8'($past(pc_o) - $past(imm)));

    // R5
    fwd_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted_o && op == 4'b1010 && flag_i)
        |=> pc_o == 8'($past(pc_o) + $past(imm)));

    // R6
    untaken_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted_o && (op == 4'b1010 || op == 4'b1011) && !flag_i)
        |=> pc_o == 8'($past(pc_o) + 8'd2));

    // R7
    halt_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted_o && op == 4'b1001) |=> (halted_o && $stable(pc_o)));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && $stable(pc_o)));
endmodule

bind pc_fetch_unit pcf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .flag_i   (flag_i),
    .pc_o     (pc_o),
    .instr_o  (instr_o),
    .halted_o (halted_o)
);

// File: tb/pc_fetch_unit_test.sv
module pc_fetch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flag = 1'b0;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [7:0]  pc;
    logic [15:0] instr;
    logic        halted;

    int checks = 0;
    int passed = 0;

    always #10 clk = ~clk;

    pc_fetch_unit uut (
        .clk         (clk),
        .rst         (rst),
        .flag_i      (flag),
        .load_en_i   (ld_en),
        .load_addr_i (ld_addr),
        .load_data_i (ld_data),
        .pc_o        (pc),
        .instr_o     (instr),
        .halted_o    (halted)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (ok) passed++;
        else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        tick();
        ld_en = 1'b0;
    endtask

    function automatic logic [7:0] even_byte(input int a);
        return {4'h4, 4'(a >> 1)};
    endfunction

    function automatic logic [7:0] odd_byte(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    initial begin
        #(20 * 190000);
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", passed, checks);
        $finish;
    end

    initial begin
        int ops [4] = '{4, 9, 10, 11};
        int bases [3] = '{38, 100, 254};
        tick(); tick();
        // R1: reset state
        chk(pc == 0, "R1 pc", pc, 0);
        chk(halted == 0, "R1 halted", halted, 0);

        // R2, R3, R8, R9: fill memory with stepping opcodes, walk it whole
        for (int a = 0; a < 256; a++) begin
            wr(8'(a), (a % 2 == 0) ? even_byte(a) : odd_byte(a));
        end
        rst = 1'b0;
        for (int k = 0; k < 128; k++) begin
            flag = k[0];
            chk(pc == 8'(2 * k), "R3 step", pc, 2 * k);
            chk(instr == {even_byte(2 * k), odd_byte(2 * k + 1)}, "R2 R9 word",
                instr, {even_byte(2 * k), odd_byte(2 * k + 1)});
            tick();
        end
        chk(pc == 0, "R8 wrap after full pass", pc, 0);

        // R4, R5, R6, R7, R8: sweep opcode, flag, base and immediate
        foreach (ops[oi]) begin
            foreach (bases[bi]) begin
                for (int imm = 0; imm < 256; imm += 3) begin
                    for (int f = 0; f < 2; f++) begin
                        int b = bases[bi];
                        int e;
                        string tag;
                        rst = 1'b1;
                        wr(8'd0, 8'hA0);
                        wr(8'd1, 8'(b));
                        wr(8'(b), {4'(ops[oi]), 4'h3});
                        wr(8'(b + 1), 8'(imm));
                        flag = 1'b1;
                        rst = 1'b0;
                        tick();
                        chk(pc == 8'(b), "R5 reach base", pc, b);
                        flag = f[0];
                        tick();
                        if (ops[oi] == 11 && f == 1) begin e = (b - imm) & 255; tag = "R4 bwd"; end
                        else if (ops[oi] == 10 && f == 1) begin e = (b + imm) & 255; tag = "R5 fwd"; end
                        else if (ops[oi] == 9) begin e = b; tag = "R7 halt pc"; end
                        else if (ops[oi] == 4) begin e = (b + 2) & 255; tag = "R3 flag ignored"; end
                        else begin e = (b + 2) & 255; tag = "R6 untaken"; end
                        if (b + imm > 255 || b - imm < 0) tag = {tag, " R8"};
                        chk(pc == 8'(e), tag, pc, e);
                        chk(halted == (ops[oi] == 9), "R7 halted", halted, ops[oi] == 9);
                    end
                end
            end
        end

        // R7: frozen under flag toggles and rewritten memory, then R1 reset
        rst = 1'b1;
        wr(8'd0, 8'hA0);
        wr(8'd1, 8'd38);
        wr(8'd38, 8'h90);
        flag = 1'b1;
        rst = 1'b0;
        tick();
        tick();
        for (int k = 0; k < 16; k++) begin
            flag = k[0];
            wr(8'd38, k[1] ? 8'hA0 : 8'hB0);
            chk(pc == 38, "R7 frozen pc", pc, 38);
            chk(halted == 1, "R7 sticky", halted, 1);
        end
        rst = 1'b1;
        tick();
        chk(pc == 0, "R1 pc after halt", pc, 0);
        chk(halted == 0, "R1 halted cleared", halted, 0);
        rst = 1'b0;
        tick();
        chk(pc == 38 && halted == 0, "R5 restart after reset", pc, 38);

        $display("%0d/%0d checks passed", passed, checks);
        $finish;
    end
endmodule